// File: doc/BRIEF.md
# Timer Status Flag Unit with Selectable Clearing

This block holds the status flags of an eight-channel capture/compare timer. Single-cycle event pulses from the timer datapath set the flags: one per channel, one for counter overflow, two for pulse accumulator A (overflow and input edge), one for pulse accumulator B overflow, and one for the modulus down-counter reaching zero. Software reaches the flags over a simple register bus with an address, a read strobe, a write strobe and write data. Read data is combinational in the cycle of the read strobe.

A mode bit picks how software clears a flag. With the mode bit at 0, software writes a one to the flag bit. With the mode bit at 1, writes to the flag registers are ignored. A flag then clears as a side effect of touching the data register the flag belongs to. The counter and data registers live in the datapath. This unit only decodes accesses to their addresses. A per-channel direction bit sets whether a read (capture) or a write (compare) of a channel's data register counts as the clearing access. A combined interrupt output reports any set flag whose enable bit is 1.

Top module: `tmr_flag_unit`

## Requirements
- R1: After reset, all flags, the mode bit, the direction bits and both enable registers read 0, and irq is 0.
- R2: A pulse on an event input sets its flag at the next clock edge. The flag then stays set until it is cleared. Channel flags read at address 0x00, bit n for channel n. Other flags read at 0x01: bit0 counter overflow, bit1 accumulator A overflow, bit2 accumulator A edge, bit3 accumulator B overflow, bit4 modulus zero.
- R3: With the mode bit at 0, a write to 0x00 or 0x01 clears each flag whose data bit is 1, and leaves each flag whose data bit is 0 unchanged.
- R4: With the mode bit at 0, reads of 0x00/0x01 and accesses to counter or data register addresses clear no flag.
- R5: With the mode bit at 1, writes to 0x00 and 0x01 change no flag.
- R6: With the mode bit at 1 and channel n's direction bit at 0, a read of 0x20+2n or 0x21+2n clears channel n's flag. A write to either address does not.
- R7: With the mode bit at 1 and channel n's direction bit at 1, a write of 0x20+2n or 0x21+2n clears channel n's flag. A read of either address does not.
- R8: With the mode bit at 1, a read or write of 0x08 or 0x09 (free-running counter) clears the counter overflow flag.
- R9: With the mode bit at 1, a read or write of 0x0A or 0x0B (accumulator A count) clears both accumulator A flags.
- R10: With the mode bit at 1, a read or write of 0x0C or 0x0D (accumulator B count) clears the accumulator B overflow flag.
- R11: With the mode bit at 1, a read or write of 0x0E or 0x0F (modulus count) clears the modulus zero flag.
- R12: When a set pulse and a clearing access hit the same flag in the same cycle, the flag ends up set.
- R13: irq is 1 exactly when some flag is 1 and its enable bit is 1. Channel enables are at 0x04 (bit n = channel n). Other enables are at 0x05, using the bit layout of 0x01.
- R14: The mode bit (0x02 bit0), the direction register (0x03, 1 = compare) and both enable registers are written and read back at their addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is 1 |
| ch_evt | input | 8 | Per-channel capture/compare event pulses |
| ovf_evt | input | 1 | Free-running counter overflow pulse |
| paa_ovf_evt | input | 1 | Accumulator A overflow pulse |
| paa_edge_evt | input | 1 | Accumulator A input edge pulse |
| pab_ovf_evt | input | 1 | Accumulator B overflow pulse |
| modz_evt | input | 1 | Modulus down-counter zero pulse |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume the bus never raises its read and write strobes in the same cycle, and one of them checks that assumption. They also assume the mode bit changes only through a bus write, so that a cycle without a write sees the same clearing scheme at both edges. The stimulus selects at most one bus operation (idle, read or write) per cycle. Event pulses are drawn independently, so set and clear collisions occur often. The directed part places such collisions on purpose.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
  localparam int AW  = 8;
  localparam int DW  = 8;
  localparam int NEV = 5;

  // bit positions of the non-channel flags (also their enable bits)
  localparam int EV_OVF   = 0;
  localparam int EV_AOVF  = 1;
  localparam int EV_AEDGE = 2;
  localparam int EV_BOVF  = 3;
  localparam int EV_MODZ  = 4;

  localparam logic [AW-1:0] A_CHFLG = 8'h00;
  localparam logic [AW-1:0] A_EVFLG = 8'h01;
  localparam logic [AW-1:0] A_MODE  = 8'h02;
  localparam logic [AW-1:0] A_DIR   = 8'h03;
  localparam logic [AW-1:0] A_CHIE  = 8'h04;
  localparam logic [AW-1:0] A_EVIE  = 8'h05;
  localparam logic [AW-1:0] A_CNT   = 8'h08;
  localparam logic [AW-1:0] A_PAA   = 8'h0A;
  localparam logic [AW-1:0] A_PAB   = 8'h0C;
  localparam logic [AW-1:0] A_MOD   = 8'h0E;

  // a 16-bit register occupies an even/odd byte pair
  function automatic logic pair_hit(input logic [AW-1:0] addr, input logic [AW-1:0] base);
    return addr[AW-1:1] == base[AW-1:1];
  endfunction

  // write-one-to-clear mask, live only in normal mode
  function automatic logic [DW-1:0] w1c_bits(input logic fast, input logic wr,
                                             input logic hit, input logic [DW-1:0] wd);
    return (!fast && wr && hit) ? wd : '0;
  endfunction

  // next flag state: set dominates clear
  function automatic logic flag_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction
endpackage

// File: rtl/tfc_flag_bank.sv
module tfc_flag_bank #(
  parameter int N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  import tfc_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o[i] <= 1'b0;
      else        q_o[i] <= flag_next(q_o[i], set_i[i], clr_i[i]);
    end
  end
endmodule

// File: rtl/tfc_cfg_regs.sv
module tfc_cfg_regs #(
  parameter int NCH = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [tfc_pkg::AW-1:0] addr,
  input  logic                   wr,
  input  logic [tfc_pkg::DW-1:0] wdata,
  output logic                   fast_o,
  output logic [NCH-1:0]         dir_o,
  output logic [NCH-1:0]         ch_ie_o,
  output logic [tfc_pkg::NEV-1:0] ev_ie_o
);
  import tfc_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_o  <= 1'b0;
      dir_o   <= '0;
      ch_ie_o <= '0;
      ev_ie_o <= '0;
    end else if (wr) begin
      case (addr)
        A_MODE:  fast_o  <= wdata[0];
        A_DIR:   dir_o   <= NCH'(wdata);
        A_CHIE:  ch_ie_o <= NCH'(wdata);
        A_EVIE:  ev_ie_o <= NEV'(wdata);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tfc_clr_decode.sv
module tfc_clr_decode #(
  parameter int                        NCH     = 8,
  parameter logic [tfc_pkg::AW-1:0]    CH_BASE = 8'h20
) (
  input  logic                    fast,
  input  logic [NCH-1:0]          dir,
  input  logic [tfc_pkg::AW-1:0]  addr,
  input  logic                    rd,
  input  logic                    wr,
  input  logic [tfc_pkg::DW-1:0]  wdata,
  output logic [NCH-1:0]          clr_ch,
  output logic [tfc_pkg::NEV-1:0] clr_ev
);
  import tfc_pkg::*;

  logic                 acc;
  logic [NCH-1:0]       w1c_ch;
  logic [NEV-1:0]       w1c_ev;
  logic                 f_cnt, f_paa, f_pab, f_mod;

  assign acc    = rd | wr;
  assign w1c_ch = NCH'(w1c_bits(fast, wr, addr == A_CHFLG, wdata));
  assign w1c_ev = NEV'(w1c_bits(fast, wr, addr == A_EVFLG, wdata));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [AW-1:0] BASE = CH_BASE + AW'(2 * i);
    logic hit, touch;
    assign hit       = pair_hit(addr, BASE);
    assign touch     = dir[i] ? wr : rd;  // compare: write, capture: read
    assign clr_ch[i] = w1c_ch[i] | (fast & hit & touch);
  end

  assign f_cnt = fast & acc & pair_hit(addr, A_CNT);
  assign f_paa = fast & acc & pair_hit(addr, A_PAA);
  assign f_pab = fast & acc & pair_hit(addr, A_PAB);
  assign f_mod = fast & acc & pair_hit(addr, A_MOD);

  assign clr_ev[EV_OVF]   = w1c_ev[EV_OVF]   | f_cnt;
  assign clr_ev[EV_AOVF]  = w1c_ev[EV_AOVF]  | f_paa;
  assign clr_ev[EV_AEDGE] = w1c_ev[EV_AEDGE] | f_paa;
  assign clr_ev[EV_BOVF]  = w1c_ev[EV_BOVF]  | f_pab;
  assign clr_ev[EV_MODZ]  = w1c_ev[EV_MODZ]  | f_mod;
endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit #(
  parameter int                     NCH     = 8,
  parameter logic [tfc_pkg::AW-1:0] CH_BASE = 8'h20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [tfc_pkg::AW-1:0] bus_addr,
  input  logic                   bus_rd,
  input  logic                   bus_wr,
  input  logic [tfc_pkg::DW-1:0] bus_wdata,
  output logic [tfc_pkg::DW-1:0] bus_rdata,
  input  logic [NCH-1:0]         ch_evt,
  input  logic                   ovf_evt,
  input  logic                   paa_ovf_evt,
  input  logic                   paa_edge_evt,
  input  logic                   pab_ovf_evt,
  input  logic                   modz_evt,
  output logic                   irq
);
  import tfc_pkg::*;

  localparam int NF = NCH + NEV;

  logic                 mode_fast;
  logic [NCH-1:0]       ch_dir, ch_ie;
  logic [NEV-1:0]       ev_ie, ev_set, clr_ev;
  logic [NCH-1:0]       clr_ch;
  logic [NF-1:0]        flag_q, flag_set, flag_clr;
  logic [NCH-1:0]       ch_q;
  logic [NEV-1:0]       ev_q;

  assign ev_set[EV_OVF]   = ovf_evt;
  assign ev_set[EV_AOVF]  = paa_ovf_evt;
  assign ev_set[EV_AEDGE] = paa_edge_evt;
  assign ev_set[EV_BOVF]  = pab_ovf_evt;
  assign ev_set[EV_MODZ]  = modz_evt;

  assign flag_set = {ev_set, ch_evt};
  assign flag_clr = {clr_ev, clr_ch};
  assign ch_q     = flag_q[NCH-1:0];
  assign ev_q     = flag_q[NF-1:NCH];

  tfc_cfg_regs #(.NCH(NCH)) u_cfg (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .fast_o(mode_fast), .dir_o(ch_dir), .ch_ie_o(ch_ie), .ev_ie_o(ev_ie)
  );

  tfc_clr_decode #(.NCH(NCH), .CH_BASE(CH_BASE)) u_dec (
    .fast(mode_fast), .dir(ch_dir), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .wdata(bus_wdata), .clr_ch(clr_ch), .clr_ev(clr_ev)
  );

  tfc_flag_bank #(.N(NF)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(flag_set), .clr_i(flag_clr), .q_o(flag_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_CHFLG: bus_rdata = DW'(ch_q);
        A_EVFLG: bus_rdata = DW'(ev_q);
        A_MODE:  bus_rdata = DW'(mode_fast);
        A_DIR:   bus_rdata = DW'(ch_dir);
        A_CHIE:  bus_rdata = DW'(ch_ie);
        A_EVIE:  bus_rdata = DW'(ev_ie);
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq = (|(ch_q & ch_ie)) | (|(ev_q & ev_ie));
endmodule

// File: rtl/tfc_checker.sv
module tfc_checker #(
  parameter int NCH = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [tfc_pkg::AW-1:0]        bus_addr,
  input logic                          bus_rd,
  input logic                          bus_wr,
  input logic                          fast,
  input logic [NCH+tfc_pkg::NEV-1:0]   flag_q,
  input logic [NCH+tfc_pkg::NEV-1:0]   flag_set,
  input logic                          irq
);
  import tfc_pkg::*;
  localparam int NF  = NCH + NEV;
  localparam int OVF = NCH + EV_OVF;

  // R12: a pulse always lands, whatever the bus does
  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set != '0) |=> ((flag_q & $past(flag_set)) == $past(flag_set)));

  // R2: a flag only rises after its own event pulse
  p_rise_needs_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(flag_set)) == '0));

  // R5: flag register writes are inert in fast mode
  p_fast_w1c_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fast && bus_wr && (bus_addr == A_CHFLG || bus_addr == A_EVFLG))
    |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R4: in normal mode nothing but a write can clear
  p_normal_no_read_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast && !bus_wr) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R8: counter access in fast mode drops overflow
  p_ovf_access_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fast && (bus_rd || bus_wr) && bus_addr[AW-1:1] == A_CNT[AW-1:1] && !flag_set[OVF])
    |=> !flag_q[OVF]);

  // R13: no interrupt without a pending flag
  p_irq_source_r13: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_q != '0));

  // R7: read/write decode assumes one strobe per cycle
  p_rd_wr_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  logic unused_nf;
  assign unused_nf = (NF > 0);
endmodule

bind tmr_flag_unit tfc_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .fast(mode_fast), .flag_q(flag_q), .flag_set(flag_set), .irq(irq)
);

// File: tb/sim_tmr_flag_unit.sv
module sim_tmr_flag_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] ch_evt = '0;
  logic       ovf_evt = 0, paa_ovf_evt = 0, paa_edge_evt = 0, pab_ovf_evt = 0, modz_evt = 0;
  logic       irq;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [12:0] mflags = '0;
  logic        mfast = 0;
  logic [7:0]  mdir = '0, mchie = '0;
  logic [4:0]  meie = '0;

  always #5 clk = ~clk;

  tmr_flag_unit u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_evt(ch_evt), .ovf_evt(ovf_evt),
    .paa_ovf_evt(paa_ovf_evt), .paa_edge_evt(paa_edge_evt), .pab_ovf_evt(pab_ovf_evt),
    .modz_evt(modz_evt), .irq(irq)
  );

  function automatic logic [12:0] clear_mask(input logic fast, input logic [7:0] dir,
      input logic [7:0] a, input logic r, input logic w, input logic [7:0] d);
    logic [12:0] c = '0;
    if (!fast) begin
      if (w && a == 8'h00) c[7:0]  = d;
      if (w && a == 8'h01) c[12:8] = d[4:0];
    end else if (r || w) begin
      if (a == 8'h08 || a == 8'h09) c[8] = 1'b1;
      if (a == 8'h0A || a == 8'h0B) c[10:9] = 2'b11;
      if (a == 8'h0C || a == 8'h0D) c[11] = 1'b1;
      if (a == 8'h0E || a == 8'h0F) c[12] = 1'b1;
      if (a >= 8'h20 && a <= 8'h2F) begin
        int k = int'(a - 8'h20) / 2;
        if (dir[k] ? w : r) c[k] = 1'b1;
      end
    end
    return c;
  endfunction

  function automatic logic [7:0] model_read(input logic [7:0] a);
    case (a)
      8'h00: return mflags[7:0];
      8'h01: return {3'b000, mflags[12:8]};
      8'h02: return {7'b0, mfast};
      8'h03: return mdir;
      8'h04: return mchie;
      8'h05: return {3'b000, meie};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic model_irq();
    return ((mflags[7:0] & mchie) != 0) || ((mflags[12:8] & meie) != 0);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // one bus cycle; read data checked against literal (has_exp) or model
  task automatic cyc(input logic [7:0] a, input logic r, input logic w, input logic [7:0] d,
                     input logic [12:0] e, input string tag = "", input logic [7:0] exp = 0,
                     input bit has_exp = 0);
    @(negedge clk);
    bus_addr = a; bus_rd = r; bus_wr = w; bus_wdata = d;
    {modz_evt, pab_ovf_evt, paa_edge_evt, paa_ovf_evt, ovf_evt, ch_evt} = e;
    #1;
    chk("R13 irq", {7'b0, irq}, {7'b0, model_irq()});
    if (r && a <= 8'h05) begin
      if (has_exp) chk(tag, bus_rdata, exp);
      else chk(a <= 8'h01 ? "R2 flag read" : "R14 config read", bus_rdata, model_read(a));
    end
    mflags = (mflags & ~clear_mask(mfast, mdir, a, r, w, d)) | e;
    if (w) begin
      case (a)
        8'h02: mfast = d[0];
        8'h03: mdir  = d;
        8'h04: mchie = d;
        8'h05: meie  = d[4:0];
        default: ;
      endcase
    end
  endtask

  task automatic wr_t(input logic [7:0] a, input logic [7:0] d, input logic [12:0] e = 0);
    cyc(a, 1'b0, 1'b1, d, e);
  endtask
  task automatic rd_t(input logic [7:0] a, input logic [12:0] e = 0);
    cyc(a, 1'b1, 1'b0, 8'h00, e);
  endtask
  task automatic rd_exp(input logic [7:0] a, input logic [7:0] exp, input string tag);
    cyc(a, 1'b1, 1'b0, 8'h00, 13'h0, tag, exp, 1'b1);
  endtask
  task automatic irq_exp(input logic exp, input string tag);
    cyc(8'h40, 1'b0, 1'b0, 8'h00, 13'h0);
    @(negedge clk);
    bus_rd = 0; bus_wr = 0; bus_addr = 8'h40;
    {modz_evt, pab_ovf_evt, paa_edge_evt, paa_ovf_evt, ovf_evt, ch_evt} = '0;
    #1;
    chk(tag, {7'b0, irq}, {7'b0, exp});
  endtask

  initial begin : watchdog
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    #1;
    chk("R1 irq at reset", {7'b0, irq}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: everything zero after reset
    for (int a = 0; a < 6; a++) rd_exp(8'(a), 8'h00, "R1 reset value");

    // R2: events set flags and they hold
    cyc(8'h40, 0, 0, 0, 13'h108);
    rd_exp(8'h00, 8'h08, "R2 channel 3 set");
    rd_exp(8'h01, 8'h01, "R2 overflow set");

    // R4: normal mode, reads and data accesses do not clear
    rd_t(8'h08); wr_t(8'h09, 8'h55); rd_t(8'h26); wr_t(8'h27, 8'h00);
    rd_exp(8'h00, 8'h08, "R4 channel kept");
    rd_exp(8'h01, 8'h01, "R4 overflow kept");

    // R3: write-one-to-clear
    wr_t(8'h00, 8'h00);
    rd_exp(8'h00, 8'h08, "R3 zero write no effect");
    wr_t(8'h00, 8'h08);
    rd_exp(8'h00, 8'h00, "R3 channel cleared");
    wr_t(8'h01, 8'h01);
    rd_exp(8'h01, 8'h00, "R3 overflow cleared");

    // R14: config read back
    wr_t(8'h02, 8'h01); wr_t(8'h03, 8'hF0); wr_t(8'h04, 8'h0F); wr_t(8'h05, 8'h1F);
    rd_exp(8'h02, 8'h01, "R14 mode");
    rd_exp(8'h03, 8'hF0, "R14 direction");
    rd_exp(8'h04, 8'h0F, "R14 channel enables");
    rd_exp(8'h05, 8'h1F, "R14 event enables");

    // R5: fast mode ignores flag writes
    cyc(8'h40, 0, 0, 0, 13'h1FFF);
    wr_t(8'h00, 8'hFF); wr_t(8'h01, 8'h1F);
    rd_exp(8'h00, 8'hFF, "R5 channel flags kept");
    rd_exp(8'h01, 8'h1F, "R5 event flags kept");

    // R6: capture channel 2 clears on read only
    wr_t(8'h24, 8'h12);
    rd_exp(8'h00, 8'hFF, "R6 write to capture no clear");
    rd_t(8'h25);
    rd_exp(8'h00, 8'hFB, "R6 capture read clears");

    // R7: compare channel 5 clears on write only
    rd_t(8'h2A);
    rd_exp(8'h00, 8'hFB, "R7 read of compare no clear");
    wr_t(8'h2B, 8'h34);
    rd_exp(8'h00, 8'hDB, "R7 compare write clears");

    // R8..R11: associated register accesses
    rd_t(8'h09);
    rd_exp(8'h01, 8'h1E, "R8 counter access clears overflow");
    wr_t(8'h0A, 8'h00);
    rd_exp(8'h01, 8'h18, "R9 accumulator A clears both");
    rd_t(8'h0D);
    rd_exp(8'h01, 8'h10, "R10 accumulator B clears");
    wr_t(8'h0E, 8'h00);
    rd_exp(8'h01, 8'h00, "R11 modulus clears");

    // R12: set beats clear, in both modes
    rd_t(8'h08, 13'h100);
    rd_exp(8'h01, 8'h01, "R12 fast mode set wins");
    wr_t(8'h02, 8'h00);
    wr_t(8'h00, 8'hFF, 13'h001);
    rd_exp(8'h00, 8'h01, "R12 normal mode set wins");

    // R13: interrupt follows enables
    wr_t(8'h00, 8'hFF); wr_t(8'h01, 8'hFF);
    irq_exp(1'b0, "R13 all clear");
    cyc(8'h40, 0, 0, 0, 13'h040);
    irq_exp(1'b0, "R13 disabled channel");
    cyc(8'h40, 0, 0, 0, 13'h002);
    irq_exp(1'b1, "R13 enabled channel");
    wr_t(8'h04, 8'h00);
    irq_exp(1'b0, "R13 enable removed");
    cyc(8'h40, 0, 0, 0, 13'h1000);
    irq_exp(1'b1, "R13 modulus enabled");

    // random phase against the model
    for (int n = 0; n < 4000; n++) begin
      int pick = int'($urandom % 20);
      int op   = int'($urandom % 3);
      logic [7:0]  a;
      logic [12:0] e = '0;
      if (pick < 6)       a = 8'(pick);
      else if (pick < 14) a = 8'(8 + pick - 6);
      else if (pick < 19) a = 8'h20 + 8'($urandom % 16);
      else                a = 8'h40;
      for (int b = 0; b < 13; b++) e[b] = ($urandom % 12) == 0;
      cyc(a, op == 1, op == 2, 8'($urandom), e);
    end

    for (int a = 0; a < 6; a++) rd_t(8'(a));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule